// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block selects which of eight interrupt lines should be presented to the processor next. Its inputs are the raw request vector, the mask vector and the in-service vector of an interrupt controller, plus three mode flags. From these it produces a registered winner: a valid flag, the number of the winning line, and the interrupt output level.

Priority is relative to a rotation offset held inside the block. The line at the offset ranks highest, and the others follow in ascending order with wrap-around. A pending line wins only when it strictly outranks every line currently in service. Two mode flags change the in-service set that is used for that comparison:
- special-mask mode drops masked lines from it;
- fully-nested mode on a master drops the cascade line from it.

A one-cycle load port rewrites the offset.

Register programming, request edge capture and the acknowledge sequence belong to neighbouring logic. Here they appear only as input vectors.

Top module: `irq_resolver`

## Requirements
- R1: The priority of line n is (n - offset) mod 8, where 0 is the best. Among pending lines, the one with the lowest priority value is chosen.
- R2: Pending lines are `req & ~mask`. When nothing is pending, `win_valid`=0, `win_line`=0 and `int_out`=0.
- R3: A pending line wins only if its priority value is strictly smaller than the smallest priority value in the effective in-service set. An equal or worse value gives no winner.
- R4: With `spec_mask`=1, the effective in-service set is `insvc & ~mask`. With `spec_mask`=0 it is `insvc` unmasked.
- R5: With `nested_mode`=1 and `is_master`=1, in-service bit 2 (the cascade line) is left out of the effective set. With `is_master`=0 that bit still counts.
- R6: `win_line` reports the line number, (winning priority + offset) mod 8, and not the priority value.
- R7: `int_out` is 1 exactly when `win_valid` is 1.
- R8: When `rot_load`=1 at a clock edge, the offset becomes `rot_value`. Outputs registered at that same edge still use the old offset; the new offset shows from the next edge on.
- R9: A synchronous reset sets the offset to 0 (line 0 highest) and clears all outputs.
- R10: The outputs are registered. They reflect the inputs sampled at the most recent rising edge and do not follow input changes between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 8 | Request vector |
| mask | input | 8 | Mask vector, 1 = masked |
| insvc | input | 8 | In-service vector |
| spec_mask | input | 1 | Special-mask mode |
| nested_mode | input | 1 | Fully-nested mode (cascade line exempt on master) |
| is_master | input | 1 | 1 = master role |
| rot_load | input | 1 | Load the rotation offset |
| rot_value | input | 3 | New rotation offset |
| win_valid | output | 1 | A winning line exists |
| win_line | output | 3 | Winning line number |
| int_out | output | 1 | Interrupt output level |

## Verification
On every cycle the assertions check the following:
- a reported winner was actually pending one edge earlier;
- no winner appears when nothing was pending;
- an empty in-service set with a pending line always yields a winner;
- the idle line number is zero;
- the interrupt level tracks the valid flag.

Only the bench's scenarios can show the rest:
- the exact choice among several pending lines under each rotation offset;
- the strict comparison against in-service lines;
- the effect of the two in-service exemption modes;
- the one-edge lag of an offset load.

The bench shows these by a sweep over every offset and every mode combination, checked against an arithmetic model.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;
  localparam int LINES      = 8;
  localparam int IDX_W      = $clog2(LINES);
  localparam int CASC_LINE  = 2;
  typedef logic [LINES-1:0] line_vec_t;
  typedef logic [IDX_W-1:0] line_idx_t;
endpackage

// File: rtl/irq_offset_reg.sv
module irq_offset_reg #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] value,
  output logic [IDX_W-1:0] offset
);
  always_ff @(posedge clk) begin
    if (rst)       offset <= '0;
    else if (load) offset <= value;
  end
endmodule

// File: rtl/irq_prio_find.sv
// Finds the best (smallest) rotated priority among the set bits of vec.
module irq_prio_find #(
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] vec,
  input  logic [IDX_W-1:0] offset,
  output logic             found,
  output logic [IDX_W-1:0] prio
);
  logic [LINES-1:0] rot;

  for (genvar g = 0; g < LINES; g++) begin : g_rot
    // Position g in rot holds the line whose priority value is g.
    assign rot[g] = vec[IDX_W'(g) + offset];
  end

  always_comb begin
    found = 1'b0;
    prio  = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (rot[i]) begin
        found = 1'b1;
        prio  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_resolver_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] req,
  input  logic [7:0] mask,
  input  logic [7:0] insvc,
  input  logic       spec_mask,
  input  logic       nested_mode,
  input  logic       is_master,
  input  logic       rot_load,
  input  logic [2:0] rot_value,
  output logic       win_valid,
  output logic [2:0] win_line,
  output logic       int_out
);
  line_idx_t offset_q;
  line_vec_t pending, cur_set, casc_bit;
  logic      p_found, c_found, win;
  line_idx_t p_prio, c_prio;

  irq_offset_reg #(.IDX_W(IDX_W)) u_offset (
    .clk(clk), .rst(rst), .load(rot_load), .value(rot_value), .offset(offset_q)
  );

  assign pending  = req & ~mask;
  assign casc_bit = line_vec_t'(1) << CASC_LINE;

  always_comb begin
    cur_set = insvc;
    if (spec_mask)                cur_set = cur_set & ~mask;
    if (nested_mode && is_master) cur_set = cur_set & ~casc_bit;
  end

  irq_prio_find #(.LINES(LINES)) u_pend_find (
    .vec(pending), .offset(offset_q), .found(p_found), .prio(p_prio)
  );

  irq_prio_find #(.LINES(LINES)) u_svc_find (
    .vec(cur_set), .offset(offset_q), .found(c_found), .prio(c_prio)
  );

  assign win = p_found && (!c_found || (p_prio < c_prio));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid <= 1'b0;
      win_line  <= '0;
      int_out   <= 1'b0;
    end else begin
      win_valid <= win;
      win_line  <= win ? line_idx_t'(p_prio + offset_q) : '0;
      int_out   <= win;
    end
  end
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] req,
  input logic [7:0] mask,
  input logic [7:0] insvc,
  input logic       win_valid,
  input logic [2:0] win_line,
  input logic       int_out
);
  logic       primed;
  logic [7:0] pend_d, insvc_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed  <= 1'b0;
      pend_d  <= '0;
      insvc_d <= '0;
    end else begin
      primed  <= 1'b1;
      pend_d  <= req & ~mask;
      insvc_d <= insvc;
    end
  end

  AST_WIN_WAS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (primed && win_valid) |-> pend_d[win_line]); // R2
  AST_IDLE_NO_WIN: assert property (@(posedge clk) disable iff (rst)
    (primed && pend_d == 8'h00) |-> !win_valid); // R2
  AST_EMPTY_SVC_WINS: assert property (@(posedge clk) disable iff (rst)
    (primed && insvc_d == 8'h00 && pend_d != 8'h00) |-> win_valid); // R3
  AST_IDLE_LINE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !win_valid |-> (win_line == 3'd0)); // R2
  AST_INT_TRACKS_VALID: assert property (@(posedge clk) disable iff (rst)
    int_out == win_valid); // R7
endmodule

bind irq_resolver irq_resolver_chk u_chk (
  .clk(clk), .rst(rst), .req(req), .mask(mask), .insvc(insvc),
  .win_valid(win_valid), .win_line(win_line), .int_out(int_out)
);

// File: tb/irq_resolver_tb.sv
`timescale 1ns/100ps
module irq_resolver_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req = '0, mask = '0, insvc = '0;
  logic       spec_mask = 1'b0, nested_mode = 1'b0, is_master = 1'b0;
  logic       rot_load = 1'b0;
  logic [2:0] rot_value = '0;
  logic       win_valid, int_out;
  logic [2:0] win_line;

  int checks = 0, errors = 0;
  int off_m = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  irq_resolver u_dut (
    .clk(clk), .rst(rst), .req(req), .mask(mask), .insvc(insvc),
    .spec_mask(spec_mask), .nested_mode(nested_mode), .is_master(is_master),
    .rot_load(rot_load), .rot_value(rot_value),
    .win_valid(win_valid), .win_line(win_line), .int_out(int_out)
  );

  function automatic int best_prio(input logic [7:0] v, input int off);
    for (int p = 0; p < 8; p++)
      if (v[(p + off) % 8]) return p;
    return 8;
  endfunction

  task automatic check(input string tag, input logic ev, input logic [2:0] el);
    checks++;
    if (win_valid !== ev || win_line !== el || int_out !== ev) begin
      errors++;
      $display("FAIL %s: valid=%0b line=%0d int=%0b expected valid=%0b line=%0d",
               tag, win_valid, win_line, int_out, ev, el);
    end
  endtask

  task automatic load_off(input int v);
    @(negedge clk);
    rot_load = 1'b1; rot_value = 3'(v);
    @(negedge clk);
    rot_load = 1'b0;
    off_m = v;
  endtask

  task automatic apply(input logic [7:0] r, m, s, input logic sm, nm, ms);
    @(negedge clk);
    req = r; mask = m; insvc = s;
    spec_mask = sm; nested_mode = nm; is_master = ms;
    @(negedge clk);
  endtask

  task automatic model_check(input string tag);
    logic [7:0] cur;
    int pp, cp;
    cur = insvc;
    if (spec_mask) cur &= ~mask;
    if (nested_mode && is_master) cur[2] = 1'b0;
    pp = best_prio(req & ~mask, off_m);
    cp = best_prio(cur, off_m);
    if (pp < cp) check(tag, 1'b1, 3'((pp + off_m) % 8));
    else         check(tag, 1'b0, 3'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    repeat (3) @(negedge clk);
    check("R9 reset outputs", 1'b0, 3'd0);
    rst = 1'b0;
    // R9: offset is 0 after reset, so line 0 ranks highest
    apply(8'hFF, 8'h00, 8'h00, 0, 0, 0);
    check("R9 offset zero", 1'b1, 3'd0);
    // R10: change inputs, sample before the next edge: old value held
    @(negedge clk);
    req = 8'h00;
    #1 check("R10 held between edges", 1'b1, 3'd0);
    @(negedge clk);
    check("R10 updated after edge", 1'b0, 3'd0);
    // R8: offset load lags by one edge
    apply(8'h21, 8'h00, 8'h00, 0, 0, 0);
    check("R8 before load", 1'b1, 3'd0);
    @(negedge clk);
    rot_load = 1'b1; rot_value = 3'd5;
    @(negedge clk);
    rot_load = 1'b0; off_m = 5;
    check("R8 same-edge old offset", 1'b1, 3'd0);
    @(negedge clk);
    check("R8 new offset", 1'b1, 3'd5);
    // R1 / R6 with offset 5
    apply(8'h21, 8'h00, 8'h00, 0, 0, 0);
    check("R1 rotated winner", 1'b1, 3'd5);
    apply(8'h09, 8'h00, 8'h00, 0, 0, 0);
    check("R6 line number reported", 1'b1, 3'd0);
    // R3
    apply(8'h10, 8'h00, 8'h10, 0, 0, 0);
    check("R3 equal priority blocked", 1'b0, 3'd0);
    apply(8'h20, 8'h00, 8'h40, 0, 0, 0);
    check("R3 higher priority wins", 1'b1, 3'd5);
    apply(8'h40, 8'h00, 8'h20, 0, 0, 0);
    check("R3 lower priority blocked", 1'b0, 3'd0);
    // R4 / R5 at offset 0
    load_off(0);
    apply(8'h08, 8'h02, 8'h02, 0, 0, 0);
    check("R4 mode off blocks", 1'b0, 3'd0);
    apply(8'h08, 8'h02, 8'h02, 1, 0, 0);
    check("R4 masked in-service ignored", 1'b1, 3'd3);
    apply(8'h08, 8'h00, 8'h04, 0, 1, 1);
    check("R5 master cascade ignored", 1'b1, 3'd3);
    apply(8'h08, 8'h00, 8'h04, 0, 1, 0);
    check("R5 slave cascade counts", 1'b0, 3'd0);
    apply(8'h08, 8'h00, 8'h04, 0, 0, 1);
    check("R5 mode off on master", 1'b0, 3'd0);
    // R2
    apply(8'hFF, 8'hFF, 8'h00, 0, 0, 0);
    check("R2 all masked", 1'b0, 3'd0);
    // Sweep: every offset, every mode combination, pseudo-random vectors
    lf = 8'hA5;
    for (int o = 0; o < 8; o++) begin
      load_off(o);
      for (int md = 0; md < 8; md++) begin
        for (int k = 0; k < 40; k++) begin
          logic [7:0] r, m, s;
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]}; r = lf;
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]}; m = lf & lf[7:0] >> 1;
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]}; s = lf & 8'h55 ^ 8'(k);
          apply(r, m, s, md[0], md[1], md[2]);
          model_check("R1 R3 R4 R5 R6 R7 sweep");
        end
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule